// File: doc/BRIEF.md
# Variable-Length Instruction Parceler

This block sits between instruction fetch and decode. Each cycle it can accept a fetch group of four 32-bit words, which is eight 16-bit parcels. It cuts that group into instructions of one or two parcels. Up to four instructions leave per beat, in program order, in fixed output slots. For each instruction the first-parcel fields are split out, and for a two-parcel instruction the 16-bit immediate is split out as well.

A group can hold up to eight one-parcel instructions, which is more than one beat carries. The parcels that are not yet used stay in the block, and the fetch side is held off until the group is used up.

An instruction never crosses a cache line, but it may cross a fetch-group boundary inside a line. When the last parcel of a group opens a two-parcel instruction, that parcel is kept. It is joined with the first parcel of the next group.

A redirect flushes everything held in the block. The next accepted group is then parsed from a given parcel offset.

Top module: `vlp_parceler`

## Requirements
- R1: Parcel j of a group is in_data[16j+15:16j], so the lower halfword of each word comes first. Bit 15 of a first parcel set to 1 marks a two-parcel instruction, and 0 marks a one-parcel instruction. All instructions of a parcel stream leave in program order, each exactly once.
- R2: Output slot k occupies out_insn[33k+32:33k] as {op[6:0], acc[2:0], reg_or_imm[5:0], imm16[15:0], two_parcel}. The first parcel supplies the fields in this order: op from bits 15:9, acc from bits 8:6, reg_or_imm from bits 5:0. For a two-parcel instruction, imm16 is the second parcel. For a one-parcel instruction, imm16 is zero. A slot that is not valid reads as all zeros.
- R3: A beat carries one to four instructions. They fill the slots from slot 0 upward with no gaps, and the maximum is always taken: a beat ends only after four slots, at the end of the held parcels, or at a held half-instruction.
- R4: When a group holds more than four instructions, the rest are presented on the following beats. in_ready stays low while any parcel of the group is still unused.
- R5: When the last parcel of a group is the first parcel of a two-parcel instruction, the instructions before it are still presented. That parcel is then held, in_ready rises, and it is emitted in slot 0 together with parcel 0 of the next group.
- R6: While out_valid is high and out_ready is low, out_slot_vld and out_insn stay unchanged. A beat is consumed only on out_valid && out_ready.
- R7: in_ready is high exactly when no unused parcel of a group is held and redirect is low. A group is taken on in_valid && in_ready.
- R8: A redirect discards all held parcels, including a held half-instruction, and out_valid is low in the next cycle. The next accepted group is parsed from parcel redirect_ofs, and later groups are parsed from parcel 0.
- R9: After reset nothing is held: in_ready is 1, out_valid is 0, and the first group is parsed from parcel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch group present |
| in_ready | output | 1 | Block can take a fetch group |
| in_data | input | 128 | Eight parcels, parcel j at bits 16j+15:16j |
| redirect | input | 1 | Flush held parcels and set the start offset |
| redirect_ofs | input | 3 | Parcel offset for the next accepted group |
| out_valid | output | 1 | At least one instruction slot valid |
| out_ready | input | 1 | Next stage takes the beat |
| out_slot_vld | output | 4 | Per-slot valid, contiguous from slot 0 |
| out_insn | output | 132 | Four 33-bit decoded slots |

## Verification
Every output of the block depends only on registered state, and in_ready also follows redirect directly. A group accepted at one rising edge therefore produces its first beat right after that edge, and each beat accepted at an edge is followed by the next beat at once. The bench drives inputs at the falling edge and samples one time unit later, before the next rising edge. Each sample matches the state left by the previous edge. The directed cases expect the beat contents cycle by cycle, in particular the half-instruction held across groups and the flush one cycle after redirect. The random stream compares slots in order against a queue that is built from the parcels as they are generated.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  localparam int PARCEL_W = 16;
  localparam int OP_W     = 7;
  localparam int ACC_W    = 3;
  localparam int RF_W     = 6;
  localparam int IMM_W    = 16;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [ACC_W-1:0] acc;
    logic [RF_W-1:0]  rf;
    logic [IMM_W-1:0] imm;
    logic             two_parcel;
  } vlp_insn_t;

  localparam int INSN_W = $bits(vlp_insn_t);

  // Top bit of a leading parcel marks a two-parcel instruction.
  function automatic logic parcel_is_long(input logic [PARCEL_W-1:0] p);
    return p[PARCEL_W-1];
  endfunction

  function automatic vlp_insn_t split_fields(input logic [PARCEL_W-1:0] lead,
                                             input logic [PARCEL_W-1:0] tail);
    vlp_insn_t r;
    r.op         = lead[15:9];
    r.acc        = lead[8:6];
    r.rf         = lead[5:0];
    r.two_parcel = parcel_is_long(lead);
    r.imm        = r.two_parcel ? tail : '0;
    return r;
  endfunction
endpackage

// File: rtl/vlp_window.sv
module vlp_window #(
  parameter int NPARC = 8
) (
  input  logic [NPARC*16-1:0]   grp,
  input  logic [15:0]           carry_p,
  output logic [NPARC:0][15:0]  win
);
  // Window slot 0 is the held half-instruction, slots 1..NPARC the group.
  assign win[0] = carry_p;
  for (genvar j = 0; j < NPARC; j++) begin : g_win
    assign win[j+1] = grp[16*j +: 16];
  end
endmodule

// File: rtl/vlp_scan.sv
module vlp_scan
  import vlp_pkg::*;
#(
  parameter int NPARC = 8,
  parameter int NSLOT = 4,
  parameter int PW    = 4
) (
  input  logic [NPARC:0][15:0]     win,
  input  logic [PW-1:0]            pos,
  output logic [NSLOT-1:0]         slot_vld,
  output logic [NSLOT-1:0][15:0]   slot_a,
  output logic [NSLOT-1:0][15:0]   slot_b,
  output logic [PW-1:0]            next_pos,
  output logic                     carry_stop
);
  localparam int WIN = NPARC + 1;
  localparam logic [PW-1:0] WIN_P  = PW'(WIN);
  localparam logic [PW-1:0] LAST_P = PW'(WIN - 1);

  always_comb begin : scan
    logic [PW-1:0] p;
    logic          stop;
    p          = pos;
    stop       = 1'b0;
    carry_stop = 1'b0;
    for (int k = 0; k < NSLOT; k++) begin
      slot_vld[k] = 1'b0;
      slot_a[k]   = (p < WIN_P) ? win[p] : '0;
      slot_b[k]   = (p < LAST_P) ? win[p + PW'(1)] : '0;
      if (!stop && p < WIN_P) begin
        if (parcel_is_long(slot_a[k])) begin
          if (p == LAST_P) begin
            stop       = 1'b1;
            carry_stop = 1'b1;
          end else begin
            slot_vld[k] = 1'b1;
            p           = p + PW'(2);
          end
        end else begin
          slot_vld[k] = 1'b1;
          p           = p + PW'(1);
        end
      end else begin
        stop = 1'b1;
      end
    end
    next_pos = p;
  end
endmodule

// File: rtl/vlp_extract.sv
module vlp_extract
  import vlp_pkg::*;
#(
  parameter int NSLOT = 4
) (
  input  logic [NSLOT-1:0]        slot_vld,
  input  logic [NSLOT-1:0][15:0]  slot_a,
  input  logic [NSLOT-1:0][15:0]  slot_b,
  output logic [NSLOT*INSN_W-1:0] insn
);
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign insn[INSN_W*k +: INSN_W] =
      slot_vld[k] ? split_fields(slot_a[k], slot_b[k]) : '0;
  end
endmodule

// File: rtl/vlp_parceler.sv
module vlp_parceler
  import vlp_pkg::*;
#(
  parameter int NPARC = 8,
  parameter int NSLOT = 4,
  localparam int OW   = $clog2(NPARC),
  localparam int IW   = vlp_pkg::INSN_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [NPARC*16-1:0]   in_data,
  input  logic                  redirect,
  input  logic [OW-1:0]         redirect_ofs,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [NSLOT-1:0]      out_slot_vld,
  output logic [NSLOT*IW-1:0]   out_insn
);
  localparam int WIN = NPARC + 1;
  localparam int PW  = $clog2(WIN + 1);

  logic [NPARC*16-1:0]  grp_q;
  logic                 full_q;
  logic [PW-1:0]        pos_q;
  logic                 carry_v_q;
  logic [15:0]          carry_p_q;
  logic [OW-1:0]        start_ofs_q;

  logic [NPARC:0][15:0] win;
  logic [NSLOT-1:0]     slot_vld;
  logic [NSLOT-1:0][15:0] slot_a, slot_b;
  logic [PW-1:0]        next_pos;
  logic                 carry_stop;

  // Named events used by the checker.
  logic grp_fire, beat_fire, advance, carry_take;

  vlp_window #(.NPARC(NPARC)) u_win (
    .grp(grp_q), .carry_p(carry_p_q), .win(win)
  );

  vlp_scan #(.NPARC(NPARC), .NSLOT(NSLOT), .PW(PW)) u_scan (
    .win(win), .pos(pos_q), .slot_vld(slot_vld), .slot_a(slot_a),
    .slot_b(slot_b), .next_pos(next_pos), .carry_stop(carry_stop)
  );

  vlp_extract #(.NSLOT(NSLOT)) u_ext (
    .slot_vld(out_slot_vld), .slot_a(slot_a), .slot_b(slot_b), .insn(out_insn)
  );

  assign out_slot_vld = full_q ? slot_vld : '0;
  assign out_valid    = |out_slot_vld;
  assign in_ready     = !full_q && !redirect;
  assign grp_fire     = in_valid && in_ready;
  assign beat_fire    = out_valid && out_ready;
  assign advance      = full_q && !redirect && (!out_valid || out_ready);
  assign carry_take   = advance && carry_stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q       <= '0;
      full_q      <= 1'b0;
      pos_q       <= '0;
      carry_v_q   <= 1'b0;
      carry_p_q   <= '0;
      start_ofs_q <= '0;
    end else if (redirect) begin
      full_q      <= 1'b0;
      carry_v_q   <= 1'b0;
      start_ofs_q <= redirect_ofs;
    end else if (grp_fire) begin
      grp_q       <= in_data;
      full_q      <= 1'b1;
      pos_q       <= carry_v_q ? '0 : PW'(start_ofs_q) + PW'(1);
      start_ofs_q <= '0;
    end else if (advance) begin
      if (carry_stop) begin
        full_q    <= 1'b0;
        carry_v_q <= 1'b1;
        carry_p_q <= grp_q[(NPARC-1)*16 +: 16];
      end else begin
        carry_v_q <= 1'b0;
        pos_q     <= next_pos;
        if (next_pos == PW'(WIN)) full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vlp_parceler_chk.sv
module vlp_parceler_chk #(
  parameter int NSLOT = 4,
  parameter int IW    = 33
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             redirect,
  input logic             out_valid,
  input logic             out_ready,
  input logic [NSLOT-1:0] out_slot_vld,
  input logic [NSLOT*IW-1:0] out_insn,
  input logic             carry_take
);
  AST_SLOT_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_slot_vld[0] &&
                  (((out_slot_vld + NSLOT'(1)) & out_slot_vld) == '0)); // R3

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid); // R7

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !redirect) |=>
      ($stable(out_slot_vld) && $stable(out_insn))); // R6

  AST_REDIRECT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !out_valid); // R8

  AST_CARRY_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    carry_take |=> (in_ready || redirect)); // R5
endmodule

bind vlp_parceler vlp_parceler_chk #(.NSLOT(NSLOT), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .redirect(redirect),
  .out_valid(out_valid), .out_ready(out_ready), .out_slot_vld(out_slot_vld),
  .out_insn(out_insn), .carry_take(carry_take)
);

// File: tb/tb_vlp_parceler.sv
`timescale 1ns/1ps
module tb_vlp_parceler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [127:0] in_data = '0;
  logic redirect = 1'b0;
  logic [2:0] redirect_ofs = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [3:0] out_slot_vld;
  logic [131:0] out_insn;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  vlp_parceler dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .redirect(redirect), .redirect_ofs(redirect_ofs),
    .out_valid(out_valid), .out_ready(out_ready), .out_slot_vld(out_slot_vld),
    .out_insn(out_insn)
  );

  logic [15:0] gp[8];
  logic [32:0] ev[4];
  logic [32:0] expq[$];
  logic [127:0] grps[$];

  function automatic logic [32:0] expect_insn(input logic [15:0] a, input logic [15:0] b);
    return {a[15:9], a[8:6], a[5:0], (a[15] ? b : 16'h0), a[15]};
  endfunction

  function automatic logic [15:0] sh(input int k);
    return 16'((k * 16'h0A13 + 16'h0125)) & 16'h7FFF;
  endfunction

  function automatic logic [15:0] lg(input int k);
    return 16'((k * 16'h1C35 + 16'h0042)) | 16'h8000;
  endfunction

  function automatic logic [127:0] pack_gp();
    logic [127:0] r;
    for (int j = 0; j < 8; j++) r[16*j +: 16] = gp[j];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input bit iv, input logic [127:0] d, input bit ordy,
                       input bit rd, input logic [2:0] ofs);
    @(negedge clk);
    in_valid = iv; in_data = d; out_ready = ordy; redirect = rd; redirect_ofs = ofs;
    #1;
  endtask

  task automatic beat(input logic [3:0] vld, input string req);
    chk(out_valid == (vld != 0), req, 64'(out_valid), 64'(vld != 0));
    chk(out_slot_vld == vld, req, 64'(out_slot_vld), 64'(vld));
    for (int k = 0; k < 4; k++) begin
      if (vld[k]) chk(out_insn[33*k +: 33] == ev[k], req, 64'(out_insn[33*k +: 33]), 64'(ev[k]));
      else chk(out_insn[33*k +: 33] == 33'h0, "R2", 64'(out_insn[33*k +: 33]), 64'h0);
    end
  endtask

  task automatic fin();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    fin();
  end

  initial begin : main
    logic [127:0] g;
    int gi;
    int guard;
    void'($urandom(32'h5EED_0123));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state; then eight short instructions (R1, R3, R4, R7)
    for (int j = 0; j < 8; j++) gp[j] = sh(j);
    g = pack_gp();
    drive(1, g, 1, 0, 0);
    chk(in_ready == 1'b1, "R9", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R9", 64'(out_valid), 64'd0);
    drive(0, '0, 1, 0, 0);
    for (int k = 0; k < 4; k++) ev[k] = expect_insn(sh(k), 16'h0);
    beat(4'b1111, "R3");
    chk(in_ready == 1'b0, "R4", 64'(in_ready), 64'd0);
    drive(0, '0, 1, 0, 0);
    for (int k = 0; k < 4; k++) ev[k] = expect_insn(sh(k + 4), 16'h0);
    beat(4'b1111, "R4");
    drive(0, '0, 1, 0, 0);
    chk(in_ready == 1'b1, "R7", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R7", 64'(out_valid), 64'd0);

    // four two-parcel instructions in one group (R2)
    for (int j = 0; j < 4; j++) begin gp[2*j] = lg(j); gp[2*j+1] = 16'hBEE0 + 16'(j); end
    drive(1, pack_gp(), 1, 0, 0);
    drive(0, '0, 1, 0, 0);
    for (int k = 0; k < 4; k++) ev[k] = expect_insn(lg(k), 16'hBEE0 + 16'(k));
    beat(4'b1111, "R2");
    drive(0, '0, 1, 0, 0);
    chk(in_ready == 1'b1, "R7", 64'(in_ready), 64'd1);

    // half instruction at the end of a group (R5)
    for (int j = 0; j < 7; j++) gp[j] = sh(j + 10);
    gp[7] = lg(7);
    drive(1, pack_gp(), 1, 0, 0);
    drive(0, '0, 1, 0, 0);
    for (int k = 0; k < 4; k++) ev[k] = expect_insn(sh(k + 10), 16'h0);
    beat(4'b1111, "R5");
    drive(0, '0, 1, 0, 0);
    for (int k = 0; k < 3; k++) ev[k] = expect_insn(sh(k + 14), 16'h0);
    beat(4'b0111, "R5");
    gp[0] = 16'h7ABC;
    for (int j = 1; j < 8; j++) gp[j] = sh(j + 20);
    drive(1, pack_gp(), 1, 0, 0);
    chk(in_ready == 1'b1, "R5", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R5", 64'(out_valid), 64'd0);
    drive(0, '0, 1, 0, 0);
    ev[0] = expect_insn(lg(7), 16'h7ABC);
    for (int k = 1; k < 4; k++) ev[k] = expect_insn(sh(k + 20), 16'h0);
    beat(4'b1111, "R5");
    drive(0, '0, 1, 0, 0);
    for (int k = 0; k < 4; k++) ev[k] = expect_insn(sh(k + 24), 16'h0);
    beat(4'b1111, "R5");

    // stall holds the beat (R6)
    for (int j = 0; j < 8; j++) gp[j] = sh(j + 30);
    drive(1, pack_gp(), 0, 0, 0);
    drive(0, '0, 0, 0, 0);
    for (int k = 0; k < 4; k++) ev[k] = expect_insn(sh(k + 30), 16'h0);
    beat(4'b1111, "R6");
    drive(0, '0, 0, 0, 0);
    beat(4'b1111, "R6");
    chk(in_ready == 1'b0, "R4", 64'(in_ready), 64'd0);

    // redirect flushes the rest and sets the offset (R8)
    drive(0, '0, 0, 1, 3'd5);
    chk(in_ready == 1'b0, "R7", 64'(in_ready), 64'd0);
    drive(0, '0, 1, 0, 0);
    chk(out_valid == 1'b0, "R8", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R8", 64'(in_ready), 64'd1);
    for (int j = 0; j < 8; j++) gp[j] = sh(j + 40);
    drive(1, pack_gp(), 1, 0, 0);
    drive(0, '0, 1, 0, 0);
    for (int k = 0; k < 3; k++) ev[k] = expect_insn(sh(k + 45), 16'h0);
    beat(4'b0111, "R8");
    for (int j = 0; j < 8; j++) gp[j] = sh(j + 50);
    drive(1, pack_gp(), 1, 0, 0);
    drive(0, '0, 1, 0, 0);
    for (int k = 0; k < 4; k++) ev[k] = expect_insn(sh(k + 50), 16'h0);
    beat(4'b1111, "R8");
    drive(0, '0, 1, 0, 0);
    drive(0, '0, 1, 0, 0);

    // constrained random stream of whole lines (R1, R2, R3, R5, R6)
    for (int ln = 0; ln < 40; ln++) begin
      logic [15:0] lp[16];
      int q;
      q = 0;
      while (q < 16) begin
        if (q < 15 && ($urandom % 3) == 0) begin
          lp[q] = 16'($urandom) | 16'h8000;
          lp[q+1] = 16'($urandom);
          expq.push_back(expect_insn(lp[q], lp[q+1]));
          q += 2;
        end else begin
          lp[q] = 16'($urandom) & 16'h7FFF;
          expq.push_back(expect_insn(lp[q], 16'h0));
          q += 1;
        end
      end
      for (int h = 0; h < 2; h++) begin
        for (int j = 0; j < 8; j++) gp[j] = lp[8*h + j];
        grps.push_back(pack_gp());
      end
    end
    gi = 0;
    guard = 0;
    while ((gi < grps.size() || expq.size() != 0) && guard < 5000) begin
      guard++;
      drive(gi < grps.size(), (gi < grps.size()) ? grps[gi] : '0,
            ($urandom % 4) != 0, 0, 0);
      if (out_valid && out_ready) begin
        chk(((out_slot_vld + 4'd1) & out_slot_vld) == 4'd0 && out_slot_vld[0],
            "R3", 64'(out_slot_vld), 64'hF);
        for (int k = 0; k < 4; k++) begin
          if (out_slot_vld[k]) begin
            if (expq.size() == 0) chk(0, "R1", 64'(out_insn[33*k +: 33]), 64'h0);
            else begin
              chk(out_insn[33*k +: 33] == expq[0], "R1 R2",
                  64'(out_insn[33*k +: 33]), 64'(expq[0]));
              void'(expq.pop_front());
            end
          end
        end
      end
      if (in_valid && in_ready) gi++;
    end
    chk(expq.size() == 0, "R1", 64'(expq.size()), 64'd0);
    fin();
  end
endmodule